// File: doc/BRIEF.md
# Fault-Input Output Shutdown Controller

This block watches a set of active-low fault inputs. When it accepts a fault, it puts two groups of protected output pins into high impedance: a group of high-drive pins and the pins of one timer channel. Each fault input has its own mode bit and its own 2-bit sampling-clock field.

In edge mode, the block accepts a fault when it sees a high-to-low step between two consecutive samples. In level mode, the block accepts a fault only after sixteen back-to-back low samples. All samples are taken on the divided sampling clock chosen for that input.

An accepted fault sets a sticky per-input flag. While any flag is set, each protected pin goes high impedance if, and only if, its function-eligibility bit is 1. Software clears a flag by writing 1 to it, and the clear takes effect only once that input has returned high.

Top module: `faultshut_top`

## Requirements
- R1: After reset, every fault flag is 0 and no protected pin output is in high impedance.
- R2: Each input has a 2-bit clock field in `cfgClk[2*i+1:2*i]`. Code 01 samples every 8 system clocks, 10 every 16, and 11 every 128, all driven by a prescaler that is shared by all inputs and cleared by reset. Code 00 disables detection, so that input never sets its flag.
- R3: Each fault input passes through a two-flop synchronizer. With `cfgMode[i]`=0 (edge mode), a sample that is low when the previous sample was high sets flag i. The flag is not set within 2 clocks of the input falling. At divide-by-8, it is set within 10 clocks.
- R4: With `cfgMode[i]`=1 (level mode), flag i is set on the sixteenth consecutive low sample. A low lasting exactly 15 sample periods is not accepted; a low lasting 16 sample periods is accepted. This holds for every clock code.
- R5: In level mode, a single high sample resets the low-sample count, so two low runs of under sixteen samples each, separated by one high sample, are not accepted.
- R6: A set flag stays set until `clrFlag[i]` is 1 in a cycle where the synchronized input i is high. A clear while the input is still low has no effect.
- R7: While any flag is set, `hcHiZ` equals `hcEligible` and `tmHiZ` equals `tmEligible`. While no flag is set, both are all zeros.
- R8: A fault accepted on one input sets only that input's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| faultN | input | NF | Active-low fault inputs |
| cfgMode | input | NF | Per-input mode: 0 edge, 1 level |
| cfgClk | input | 2*NF | Per-input sampling clock select, 2 bits each |
| clrFlag | input | NF | Write-1 clear strobe per flag |
| hcEligible | input | NHC | High-drive pins whose function allows shutdown |
| tmEligible | input | NTM | Timer channel pins whose function allows shutdown |
| flags | output | NF | Sticky accepted-fault flags |
| hcHiZ | output | NHC | High-impedance enable for high-drive pins |
| tmHiZ | output | NTM | High-impedance enable for timer channel pins |

## Verification
The level filter is driven with low pulses that last exactly 15 and exactly 16 sample periods at each of the three divisors. Because any run of such a length contains a fixed number of sample ticks regardless of the prescaler phase, these pulses separate an off-by-one in the run counter or a wrong divisor from a correct filter. A low-high-low pattern with a one-period high gap shows whether a high sample really resets the count. An edge on a second input and a low on a disabled third input show that the inputs are independent and that the off code works. Eligibility patterns applied during a shutdown, together with clears attempted while the input is still low, show that the pin masking and the clear condition are correct.

// File: rtl/faultshut_pkg.sv
package faultshut_pkg;
  typedef enum logic [1:0] {
    SAMP_OFF    = 2'b00,
    SAMP_DIV_A  = 2'b01,
    SAMP_DIV_B  = 2'b10,
    SAMP_DIV_C  = 2'b11
  } sampSel_e;

  typedef struct packed {
    logic edgeHit;
    logic levelHit;
    logic idle;
  } faultStrobe_t;
endpackage

// File: rtl/faultshut_datapath.sv
module faultshut_datapath
  import faultshut_pkg::*;
#(
  parameter int NF = 9,
  parameter int FILTER_LEN = 16,
  parameter int DIV_A = 8,
  parameter int DIV_B = 16,
  parameter int DIV_C = 128
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NF-1:0]          faultN,
  input  logic [2*NF-1:0]        cfgClk,
  output faultStrobe_t [NF-1:0]  strobes
);
  localparam int PW = $clog2(DIV_C);
  localparam int AW = $clog2(DIV_A);
  localparam int BW = $clog2(DIV_B);
  localparam int CW = $clog2(FILTER_LEN);
  localparam logic [CW-1:0] LAST_RUN = CW'(FILTER_LEN - 1);

  logic [PW-1:0] preCnt;
  logic tickA, tickB, tickC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  assign tickA = &preCnt[AW-1:0];
  assign tickB = &preCnt[BW-1:0];
  assign tickC = &preCnt;

  for (genvar i = 0; i < NF; i++) begin : gInput
    logic syncA, syncB, lastSamp, tickSel;
    logic [CW-1:0] runCnt;

    always_comb begin
      case (sampSel_e'(cfgClk[2*i +: 2]))
        SAMP_DIV_A: tickSel = tickA;
        SAMP_DIV_B: tickSel = tickB;
        SAMP_DIV_C: tickSel = tickC;
        default:    tickSel = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA    <= 1'b1;
        syncB    <= 1'b1;
        lastSamp <= 1'b1;
        runCnt   <= '0;
      end else begin
        syncA <= faultN[i];
        syncB <= syncA;
        if (tickSel) begin
          lastSamp <= syncB;
          if (syncB)                   runCnt <= '0;
          else if (runCnt != LAST_RUN) runCnt <= runCnt + 1'b1;
        end
      end
    end

    assign strobes[i].edgeHit  = tickSel & lastSamp & ~syncB;
    assign strobes[i].levelHit = tickSel & ~syncB & (runCnt == LAST_RUN);
    assign strobes[i].idle     = syncB;
  end
endmodule

// File: rtl/faultshut_ctrl.sv
module faultshut_ctrl
  import faultshut_pkg::*;
#(
  parameter int NF = 9
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  faultStrobe_t [NF-1:0]  strobes,
  input  logic [NF-1:0]          cfgMode,
  input  logic [NF-1:0]          clrFlag,
  output logic [NF-1:0]          flags
);
  logic [NF-1:0] nextFlags;

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      if (cfgMode[i] ? strobes[i].levelHit : strobes[i].edgeHit)
        nextFlags[i] = 1'b1;
      else if (clrFlag[i] && strobes[i].idle)
        nextFlags[i] = 1'b0;
      else
        nextFlags[i] = flags[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= nextFlags;
  end
endmodule

// File: rtl/faultshut_top.sv
module faultshut_top
  import faultshut_pkg::*;
#(
  parameter int NF = 9,
  parameter int NHC = 6,
  parameter int NTM = 4,
  parameter int FILTER_LEN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NF-1:0]    faultN,
  input  logic [NF-1:0]    cfgMode,
  input  logic [2*NF-1:0]  cfgClk,
  input  logic [NF-1:0]    clrFlag,
  input  logic [NHC-1:0]   hcEligible,
  input  logic [NTM-1:0]   tmEligible,
  output logic [NF-1:0]    flags,
  output logic [NHC-1:0]   hcHiZ,
  output logic [NTM-1:0]   tmHiZ
);
  faultStrobe_t [NF-1:0] strobes;
  logic shutdown;

  faultshut_datapath #(.NF(NF), .FILTER_LEN(FILTER_LEN)) dp_i (
    .clk(clk), .rstN(rstN), .faultN(faultN), .cfgClk(cfgClk), .strobes(strobes)
  );

  faultshut_ctrl #(.NF(NF)) ctrl_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgMode(cfgMode),
    .clrFlag(clrFlag), .flags(flags)
  );

  assign shutdown = |flags;
  assign hcHiZ    = {NHC{shutdown}} & hcEligible;
  assign tmHiZ    = {NTM{shutdown}} & tmEligible;
endmodule

// File: rtl/faultshut_checker.sv
module faultshut_checker #(
  parameter int NF = 9,
  parameter int NHC = 6,
  parameter int NTM = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [NF-1:0]    faultN,
  input logic [2*NF-1:0]  cfgClk,
  input logic [NF-1:0]    clrFlag,
  input logic [NHC-1:0]   hcEligible,
  input logic [NTM-1:0]   tmEligible,
  input logic [NF-1:0]    flags,
  input logic [NHC-1:0]   hcHiZ,
  input logic [NTM-1:0]   tmHiZ
);
  assert_hiz_eligible_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|flags) |-> (hcHiZ == hcEligible && tmHiZ == tmEligible));

  assert_hiz_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(|flags) |-> (hcHiZ == '0 && tmHiZ == '0));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flags) & ~$past(clrFlag) & ~flags) == '0));

  for (genvar i = 0; i < NF; i++) begin : gChk
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
      (cfgClk[2*i +: 2] == 2'b00 && !flags[i]) |=> !flags[i]);

    assert_rise_needs_low_R3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[i]) |-> !$past(faultN[i], 3));
  end
endmodule

bind faultshut_top faultshut_checker #(.NF(NF), .NHC(NHC), .NTM(NTM)) chk_i (
  .clk(clk), .rstN(rstN), .faultN(faultN), .cfgClk(cfgClk), .clrFlag(clrFlag),
  .hcEligible(hcEligible), .tmEligible(tmEligible), .flags(flags),
  .hcHiZ(hcHiZ), .tmHiZ(tmHiZ)
);

// File: tb/faultshut_top_tb_top.sv
module faultshut_top_tb_top;
  localparam int NF = 9;
  localparam int NHC = 6;
  localparam int NTM = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NF-1:0]   faultN = '1;
  logic [NF-1:0]   cfgMode = '1;
  logic [2*NF-1:0] cfgClk = '0;
  logic [NF-1:0]   clrFlag = '0;
  logic [NHC-1:0]  hcEligible = '1;
  logic [NTM-1:0]  tmEligible = '1;
  logic [NF-1:0]   flags;
  logic [NHC-1:0]  hcHiZ;
  logic [NTM-1:0]  tmHiZ;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  faultshut_top dut_i (
    .clk(clk), .rstN(rstN), .faultN(faultN), .cfgMode(cfgMode), .cfgClk(cfgClk),
    .clrFlag(clrFlag), .hcEligible(hcEligible), .tmEligible(tmEligible),
    .flags(flags), .hcHiZ(hcHiZ), .tmHiZ(tmHiZ)
  );

  // level-filter table: clock code, low duration in clocks, expected flag 0
  localparam logic [1:0] V_SEL [6] = '{2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b11};
  localparam int         V_LOW [6] = '{120, 128, 240, 256, 1920, 2048};
  localparam logic       V_EXP [6] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseClr(input logic [NF-1:0] m);
    clrFlag = m;
    waitCyc(1);
    clrFlag = '0;
    waitCyc(2);
  endtask

  initial begin
    // input 0: level, per table; input 4: edge /8; input 8: disabled; rest level /8
    for (int i = 0; i < NF; i++) cfgClk[2*i +: 2] = 2'b01;
    cfgMode[4] = 1'b0;
    cfgClk[17:16] = 2'b00;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    check(32'(flags), 0, "R1 flags after reset");
    check(32'({hcHiZ, tmHiZ}), 0, "R1 hiZ after reset");

    for (int v = 0; v < 6; v++) begin
      cfgClk[1:0] = V_SEL[v];
      waitCyc(300);
      faultN[0] = 1'b0;
      waitCyc(V_LOW[v]);
      faultN[0] = 1'b1;
      waitCyc(4);
      check(32'(flags[0]), 32'(V_EXP[v]), "R4/R2 level filter table");
      check(32'(flags[NF-1:1]), 0, "R8 other flags quiet");
      waitCyc(300);
      pulseClr(9'h001);
      check(32'(flags), 0, "R6 clear after release");
    end

    // R5: one high sample between two short low runs
    cfgClk[1:0] = 2'b01;
    waitCyc(20);
    faultN[0] = 1'b0; waitCyc(100);
    faultN[0] = 1'b1; waitCyc(8);
    faultN[0] = 1'b0; waitCyc(100);
    faultN[0] = 1'b1; waitCyc(4);
    check(32'(flags), 0, "R5 high sample resets count");

    // R3 + R8: edge on input 4
    waitCyc(20);
    faultN[4] = 1'b0;
    waitCyc(2);
    check(32'(flags), 0, "R3 no accept within sync delay");
    waitCyc(10);
    check(32'(flags), 32'h010, "R3 edge accepted, R8 only input 4");
    faultN[4] = 1'b1;
    waitCyc(4);
    pulseClr(9'h010);
    check(32'(flags), 0, "R6 edge flag cleared");

    // R2: disabled input 8
    faultN[8] = 1'b0;
    waitCyc(300);
    check(32'(flags), 0, "R2 disabled input ignored");
    faultN[8] = 1'b1;
    waitCyc(4);

    // R6 + R7: clear blocked while low; eligibility masking
    faultN[0] = 1'b0;
    waitCyc(200);
    check(32'(flags[0]), 1, "R4 long low accepted");
    hcEligible = 6'b101010; tmEligible = 4'b0011;
    waitCyc(1);
    check(32'(hcHiZ), 32'h2A, "R7 high-drive mask");
    check(32'(tmHiZ), 32'h3, "R7 timer mask");
    hcEligible = 6'b000000; tmEligible = 4'b1100;
    waitCyc(1);
    check(32'({hcHiZ, tmHiZ}), 32'h0C, "R7 second mask");
    pulseClr(9'h001);
    check(32'(flags[0]), 1, "R6 clear ignored while low");
    check(32'(tmHiZ), 32'hC, "R6 shutdown held");
    faultN[0] = 1'b1;
    waitCyc(4);
    pulseClr(9'h001);
    check(32'(flags), 0, "R6 clear after input high");
    check(32'({hcHiZ, tmHiZ}), 0, "R7 released after clear");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule